// File: doc/BRIEF.md
# Fixed-Latency Integer Power Pipeline

This block raises a signed integer operand to a small power, 0 through 3. The result is registered and always appears exactly two rising clock edges after the operand and exponent were sampled, whatever the exponent is. Even the trivial powers (constant one and the operand itself) wait out the full pipeline, so a downstream consumer can use a single fixed delay for every result.

The pipeline has two stages. The first stage captures the operand and the exponent and forms the square of the operand in the same cycle. The second stage forms the cube from the registered square and the delayed operand, then selects the requested power. Each stage holds at most one multiplier, so no multiplier ever feeds another multiplier within a cycle. A new operand/exponent pair may enter on every cycle. Results wrap modulo 2^DATA_W and overflow is not flagged.

Top module: `pow_fixed_lat`

## Requirements
- R1: With exponent code 0, the output is 1 for every operand, including an operand of 0.
- R2: With exponent code 1, the output equals the operand.
- R3: With exponent code 2, the output is the operand squared, kept to the low DATA_W bits as a two's-complement value. A negative operand gives a positive square.
- R4: With exponent code 3, the output is the operand cubed, kept to the low DATA_W bits as a two's-complement value. The sign is preserved, and a cube that exceeds the range wraps.
- R5: For every exponent, the result for a pair sampled on a rising edge appears on the output after the second rising edge that follows that sample, and not earlier.
- R6: A different pair may be applied on every cycle. The results then appear back to back, in the order the pairs were applied, each one two edges after its own pair.
- R7: Reset is synchronous and active high. Any rising edge with reset high drives the output to 0, and the output stays 0 while reset is held, whatever the inputs are.
- R8: Reset clears the first stage to operand 0 with exponent code 0. After reset is released, the first rising edge therefore puts 1 on the output. The pair applied in the first cycle after release appears on the second edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| base_in | input | DATA_W | Signed operand |
| exp_in | input | 2 | Exponent code, 0 to 3 |
| pow_out | output | DATA_W | Signed registered result |

## Verification
The bench builds the block with its default DATA_W of 32, the width at which the cube of a moderate operand such as 2000 already wraps. That puts the truncation case of R4 and the sign handling of R3 within reach of plain directed values. A back-to-back stream that changes the exponent on every cycle exposes any stage that takes a shortcut for the trivial powers, because a result arriving one edge early or late lands on its neighbour's slot. Reset is asserted in the middle of a stream and released while inputs are live, which pins down the cleared-stage value that appears on the first edge after release.

// File: rtl/pow_pkg.sv
package pow_pkg;

    // Default operand / result width
    localparam int DEF_DATA_W = 32;

    // Exponent code width and number of selectable powers
    localparam int EXP_W = 2;
    localparam int N_POW = 1 << EXP_W;

    // Exponent codes; the code value is the power applied
    typedef enum logic [EXP_W-1:0] {
        PW_ONE  = 2'd0,
        PW_LIN  = 2'd1,
        PW_SQR  = 2'd2,
        PW_CUBE = 2'd3
    } pow_code_t;

    // Cast a raw exponent bus into the code type
    function automatic pow_code_t to_code(input logic [EXP_W-1:0] raw);
        return pow_code_t'(raw);
    endfunction

endpackage

// File: rtl/pow_sq_stage.sv
module pow_sq_stage
    import pow_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [DATA_W-1:0] base_d,
    input  logic [EXP_W-1:0]         exp_d,
    output logic signed [DATA_W-1:0] base_q,
    output pow_code_t                code_q,
    output logic signed [DATA_W-1:0] sq_q
);

    // Single multiplier in this stage: square of the incoming operand
    logic signed [DATA_W-1:0] sq_nxt;

    always_comb begin
        sq_nxt = base_d * base_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            code_q <= PW_ONE;
            sq_q   <= '0;
        end else begin
            base_q <= base_d;
            code_q <= to_code(exp_d);
            sq_q   <= sq_nxt;
        end
    end

endmodule

// File: rtl/pow_sel_stage.sv
module pow_sel_stage
    import pow_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [DATA_W-1:0] base_q,
    input  pow_code_t                code_q,
    input  logic signed [DATA_W-1:0] sq_q,
    output logic signed [DATA_W-1:0] res_q
);

    // Candidate powers, indexed by exponent code
    logic signed [DATA_W-1:0] cand [N_POW];

    for (genvar k = 0; k < N_POW; k++) begin : g_cand
        if (k == 0) begin : g_one
            assign cand[k] = DATA_W'(1);
        end else if (k == 1) begin : g_lin
            assign cand[k] = base_q;
        end else if (k == 2) begin : g_sqr
            assign cand[k] = sq_q;
        end else begin : g_cube
            // Single multiplier in this stage: registered square times delayed operand
            assign cand[k] = sq_q * base_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q <= cand[code_q];
        end
    end

endmodule

// File: rtl/pow_fixed_lat.sv
module pow_fixed_lat
    import pow_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [DATA_W-1:0] base_in,
    input  logic [EXP_W-1:0]         exp_in,
    output logic signed [DATA_W-1:0] pow_out
);

    logic signed [DATA_W-1:0] s1_base;
    pow_code_t                s1_code;
    logic signed [DATA_W-1:0] s1_sq;

    pow_sq_stage #(.DATA_W(DATA_W)) u_sq (
        .clk    (clk),
        .rst    (rst),
        .base_d (base_in),
        .exp_d  (exp_in),
        .base_q (s1_base),
        .code_q (s1_code),
        .sq_q   (s1_sq)
    );

    pow_sel_stage #(.DATA_W(DATA_W)) u_sel (
        .clk    (clk),
        .rst    (rst),
        .base_q (s1_base),
        .code_q (s1_code),
        .sq_q   (s1_sq),
        .res_q  (pow_out)
    );

endmodule

// File: rtl/pow_fixed_lat_chk.sv
module pow_fixed_lat_chk
    import pow_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W
) (
    input logic                     clk,
    input logic                     rst,
    input logic signed [DATA_W-1:0] base_in,
    input logic [EXP_W-1:0]         exp_in,
    input logic signed [DATA_W-1:0] pow_out,
    input logic [EXP_W-1:0]         s1_code
);

    // Independent two-deep history of the inputs
    logic signed [DATA_W-1:0] h_b1, h_b2;
    logic [EXP_W-1:0]         h_e1, h_e2;
    logic [1:0]               depth;
    logic                     full;

    always_ff @(posedge clk) begin
        h_b1 <= base_in;
        h_b2 <= h_b1;
        h_e1 <= exp_in;
        h_e2 <= h_e1;
        if (rst) begin
            depth <= '0;
        end else if (depth != 2'd2) begin
            depth <= depth + 2'd1;
        end
    end

    assign full = (depth == 2'd2);

    AST_RST_CLEARS: assert property (@(posedge clk) rst |=> (pow_out == '0)); // R7

    AST_EXP0_ONE: assert property (@(posedge clk) disable iff (rst)
        (full && h_e2 == 2'd0) |-> (pow_out == DATA_W'(1))); // R1

    AST_EXP1_PASS: assert property (@(posedge clk) disable iff (rst)
        (full && h_e2 == 2'd1) |-> (pow_out == h_b2)); // R2

    AST_EXP2_SQUARE: assert property (@(posedge clk) disable iff (rst)
        (full && h_e2 == 2'd2) |-> (pow_out == DATA_W'(h_b2 * h_b2))); // R3

    AST_EXP3_CUBE: assert property (@(posedge clk) disable iff (rst)
        (full && h_e2 == 2'd3) |-> (pow_out == DATA_W'(h_b2 * h_b2 * h_b2))); // R4

    AST_STAGE_ALIGN: assert property (@(posedge clk) disable iff (rst)
        (depth != 2'd0) |-> (s1_code == h_e1)); // R5

endmodule

bind pow_fixed_lat pow_fixed_lat_chk #(.DATA_W(DATA_W)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .base_in (base_in),
    .exp_in  (exp_in),
    .pow_out (pow_out),
    .s1_code (s1_code)
);

// File: tb/pow_fixed_lat_tb_top.sv
module pow_fixed_lat_tb_top;

    localparam int W = 32;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic signed [W-1:0] base_in = '0;
    logic [1:0]          exp_in = '0;
    logic signed [W-1:0] pow_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    pow_fixed_lat #(.DATA_W(W)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .base_in (base_in),
        .exp_in  (exp_in),
        .pow_out (pow_out)
    );

    function automatic logic signed [W-1:0] ref_pow(input logic signed [W-1:0] b, input int e);
        logic signed [W-1:0] r;
        r = 1;
        for (int k = 0; k < e; k++) r = r * b;
        return r;
    endfunction

    task automatic check(input string req, input logic signed [W-1:0] act, input logic signed [W-1:0] exp_v);
        n_checks++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    // One pair, drained, checked two edges later and not one
    task automatic single(input string req, input logic signed [W-1:0] b, input int e);
        logic signed [W-1:0] prev;
        @(negedge clk);
        base_in = b;
        exp_in  = 2'(e);
        prev    = pow_out;
        @(negedge clk);
        base_in = 0;
        exp_in  = 2'd1;
        if (ref_pow(b, e) !== prev) check({req, "/R5 early"}, pow_out, prev);
        @(negedge clk);
        check(req, pow_out, ref_pow(b, e));
    endtask

    task automatic t_reset_hold();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R7 reset", pow_out, 0);
        base_in = 9; exp_in = 2'd0;
        @(negedge clk);
        check("R7 held", pow_out, 0);
    endtask

    task automatic t_release();
        @(negedge clk);
        rst = 1'b0;
        base_in = -6; exp_in = 2'd3;
        @(negedge clk);
        base_in = 0; exp_in = 2'd1;
        check("R8 first edge", pow_out, 1);
        @(negedge clk);
        check("R8 second edge", pow_out, -216);
    endtask

    task automatic t_exp0();
        single("R1 x=0", 0, 0);
        single("R1 x=5", 5, 0);
        single("R1 x=-7", -7, 0);
    endtask

    task automatic t_exp1();
        single("R2 x=123", 123, 1);
        single("R2 x=-45", -45, 1);
        single("R2 x=min", 32'sh8000_0000, 1);
    endtask

    task automatic t_exp2();
        single("R3 x=12", 12, 2);
        single("R3 x=-9", -9, 2);
        single("R3 wrap", 70000, 2);
    endtask

    task automatic t_exp3();
        single("R4 x=-3", -3, 3);
        single("R4 x=11", 11, 3);
        single("R4 wrap", 2000, 3);
    endtask

    task automatic t_stream();
        logic signed [W-1:0] sb [8];
        int                  se [8];
        for (int k = 0; k < 8; k++) begin
            sb[k] = W'(k * 7 - 20);
            se[k] = (k * 3) % 4;
        end
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (k >= 2) check("R6 stream", pow_out, ref_pow(sb[k-2], se[k-2]));
            if (k < 8) begin
                base_in = sb[k];
                exp_in  = 2'(se[k]);
            end
        end
    endtask

    task automatic t_mid_reset();
        @(negedge clk);
        base_in = 4; exp_in = 2'd2;
        @(negedge clk);
        base_in = 5; exp_in = 2'd3;
        rst = 1'b1;
        @(negedge clk);
        check("R7 mid-stream", pow_out, 0);
        @(negedge clk);
        check("R7 mid-stream hold", pow_out, 0);
        rst = 1'b0;
        base_in = 2; exp_in = 2'd3;
        @(negedge clk);
        base_in = 0; exp_in = 2'd0;
        check("R8 re-release", pow_out, 1);
        @(negedge clk);
        check("R8 re-release pair", pow_out, 8);
    endtask

    initial begin
        t_reset_hold();
        t_release();
        t_exp0();
        t_exp1();
        t_exp2();
        t_exp3();
        t_stream();
        t_mid_reset();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule